// File: doc/BRIEF.md
# Four-Source Interrupt Controller

This block gathers four interrupt causes for a small eight-bit core: a timer that has wrapped around, a chosen edge on an external pin, a level change on any line of an eight-bit input port, and a completion flag that a nonvolatile-memory controller owns. One eight-bit control register holds the global enable, four per-source enables and three per-source flags. Software reads this register continuously and can overwrite it with a single write strobe. Hardware sets a flag when its event occurs. Only a software write clears a flag.

The request to the core is raised when the global enable is set and at least one source has both its flag and its enable set. When the core acknowledges, the block clears the global enable and, on the next cycle, presents the fixed entry address 0x0004 together with a load strobe. A return pulse sets the global enable again. Any flag that software has not cleared then raises the request once more.

Top module: `irq_gather`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `cfg_rdata` is 0x00, `irq_req` is 0 and `vec_load` is 0.
- R2: A cycle with `cfg_wr` high loads all eight bits of `cfg_wdata` into the control register, and `cfg_rdata` shows the result on the following cycle. The bit layout is: 7 global enable, 6 write-complete enable, 5 timer enable, 4 pin enable, 3 port enable, 2 timer flag, 1 pin flag, 0 port flag.
- R3: `irq_req` equals bit7 AND ((bit6 AND `nvw_done`) OR (bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0)), taken from the current register contents and input.
- R4: A cycle with `irq_ack` high clears bit 7, even if `cfg_wr` or `irq_ret` is high in the same cycle. One cycle after the acknowledge, `vec_load` is 1 and `vec_addr` is 0x0004. In every other cycle `vec_load` is 0.
- R5: A cycle with `irq_ret` high and `irq_ack` low sets bit 7.
- R6: A one-cycle `tmr_wrap` pulse sets bit 2.
- R7: When `edge_rise_sel` is 1, a 0-to-1 transition of `ext_pin` sets bit 1. When it is 0, a 1-to-0 transition sets bit 1. A transition in the other direction leaves bit 1 unchanged.
- R8: A level change on any one of the eight `port_pins` lines, compared with its value on the previous cycle, sets bit 0. A cycle in which no line changes leaves bit 0 unchanged.
- R9: A flag stays set until a write clears it. When a hardware set and a write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R10: Pin and port levels that are present when reset is released do not set bit 1 or bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Value to write |
| cfg_rdata | output | 8 | Current control register contents |
| edge_rise_sel | input | 1 | 1 selects the rising edge of `ext_pin`, 0 selects the falling edge |
| ext_pin | input | 1 | External interrupt pin, already synchronized |
| tmr_wrap | input | 1 | One-cycle pulse on timer rollover from 0xFF to 0x00 |
| port_pins | input | 8 | Monitored input port, already synchronized |
| nvw_done | input | 1 | Write-complete flag kept by the memory controller |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Core returns from the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| vec_load | output | 1 | Pulse telling the core to load `vec_addr` |
| vec_addr | output | 13 | Entry address, 0x0004 while `vec_load` is high |

## Verification
The bench provokes two kinds of coincident events. In the first, a timer pulse arrives in the same cycle as a software write that clears all flags. The bench then reads the register on the next cycle and expects the timer flag to have survived. In the second, an acknowledge coincides with a return pulse, or with a write that sets the global enable. The bench judges these by expecting the global enable to read back 0 and the vector strobe to appear exactly one cycle later. The request logic is covered by an exhaustive sweep over all 256 register values, each with the write-complete input at both levels, and every result is compared with the expected request computed in the bench.

// File: rtl/irq_gather_pkg.sv
// Package: bit positions of the control register and the event bundle
// passed from the detectors to the register.
package irq_gather_pkg;
    localparam int REG_W     = 8;
    localparam int B_GLOBAL  = 7;
    localparam int B_WC_EN   = 6;
    localparam int B_TMR_EN  = 5;
    localparam int B_PIN_EN  = 4;
    localparam int B_PORT_EN = 3;
    localparam int B_TMR_FL  = 2;
    localparam int B_PIN_FL  = 1;
    localparam int B_PORT_FL = 0;

    typedef struct packed {
        logic tmr;
        logic pin;
        logic port;
    } irq_evt_t;
endpackage

// File: rtl/irq_edge_det.sv
// Module: irq_edge_det
// Detects the selected edge of a single synchronized pin.
// Assumes: pin is already synchronous to clk; armed is low on the first
// cycle after reset so that the reset-time level is not treated as an edge.
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic pin_q;

    // Purpose: remember the pin level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // Purpose: flag the edge direction that rise_sel asks for.
    always_comb begin
        hit = armed & (rise_sel ? (pin & ~pin_q) : (~pin & pin_q));
    end
endmodule

// File: rtl/irq_port_watch.sv
// Module: irq_port_watch
// Reports a change of any port line against a copy latched on the previous cycle.
// Assumes: the lines are synchronous to clk; armed is low on the first cycle after reset.
module irq_port_watch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [WIDTH-1:0] pins,
    output logic             changed
);
    logic [WIDTH-1:0] pins_q;

    // Purpose: keep the port levels of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins;
    end

    // Purpose: report a change when any line differs from its latched copy.
    always_comb begin
        changed = armed & (|(pins ^ pins_q));
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: irq_ctrl_reg
// Eight-bit control register. It holds the enables and the flags.
// Assumes: a hardware set beats a software clear in the same cycle;
// an acknowledge clears the global enable ahead of a return or a write.
module irq_ctrl_reg
    import irq_gather_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack,
    input  logic             ret,
    input  irq_evt_t         evt,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] nxt;

    // Purpose: choose the written value or the held value as the base for the update.
    always_comb begin
        base = wr ? wdata : reg_q;
    end

    // Purpose: merge the hardware flag sets and the global-enable control into the base.
    always_comb begin
        nxt            = base;
        nxt[B_TMR_FL]  = base[B_TMR_FL]  | evt.tmr;
        nxt[B_PIN_FL]  = base[B_PIN_FL]  | evt.pin;
        nxt[B_PORT_FL] = base[B_PORT_FL] | evt.port;
        if (ack)      nxt[B_GLOBAL] = 1'b0;
        else if (ret) nxt[B_GLOBAL] = 1'b1;
    end

    // Purpose: store the register.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= nxt;
    end

    assign rdata = reg_q;
endmodule

// File: rtl/irq_gather.sv
// Module: irq_gather (top)
// Gathers the four interrupt sources, raises the request and delivers the entry address.
// Assumes: ext_pin and port_pins are synchronized upstream; tmr_wrap is a
// one-cycle pulse; nvw_done is a level owned and cleared by the memory controller.
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int          PORT_W = 8,
    parameter int          VEC_W  = 13,
    parameter logic [12:0] VEC_AT = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              edge_rise_sel,
    input  logic              ext_pin,
    input  logic              tmr_wrap,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              nvw_done,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic              vec_load,
    output logic [VEC_W-1:0]  vec_addr
);
    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(VEC_AT);

    logic     armed_q;
    irq_evt_t evt;
    logic     pin_hit;
    logic     port_hit;

    // Purpose: suppress edge and change detection on the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    irq_edge_det u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed_q),
        .pin      (ext_pin),
        .rise_sel (edge_rise_sel),
        .hit      (pin_hit)
    );

    irq_port_watch #(.WIDTH(PORT_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed_q),
        .pins    (port_pins),
        .changed (port_hit)
    );

    // Purpose: bundle the hardware events for the register.
    always_comb begin
        evt.tmr  = tmr_wrap;
        evt.pin  = pin_hit;
        evt.port = port_hit;
    end

    irq_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ack   (irq_ack),
        .ret   (irq_ret),
        .evt   (evt),
        .rdata (cfg_rdata)
    );

    // Purpose: raise the request when the global enable is set and any enabled flag is pending.
    always_comb begin
        irq_req = cfg_rdata[B_GLOBAL] &
                  ((cfg_rdata[B_WC_EN]   & nvw_done) |
                   (cfg_rdata[B_TMR_EN]  & cfg_rdata[B_TMR_FL]) |
                   (cfg_rdata[B_PIN_EN]  & cfg_rdata[B_PIN_FL]) |
                   (cfg_rdata[B_PORT_EN] & cfg_rdata[B_PORT_FL]));
    end

    // Purpose: present the entry address for one cycle after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_load <= 1'b0;
            vec_addr <= '0;
        end else begin
            vec_load <= irq_ack;
            vec_addr <= irq_ack ? VEC_VAL : '0;
        end
    end
endmodule

// File: rtl/irq_gather_chk.sv
// Module: irq_gather_chk
// Checker for irq_gather, attached with bind. It observes ports only.
module irq_gather_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_rdata,
    input logic       tmr_wrap,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       irq_req,
    input logic       vec_load,
    input logic [12:0] vec_addr
);
    p_ack_clears_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !cfg_rdata[7]);

    p_vector_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (vec_load && vec_addr == 13'h0004));

    p_ret_sets_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> cfg_rdata[7]);

    p_req_needs_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> cfg_rdata[7]);

    p_timer_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> cfg_rdata[2]);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && !cfg_wr) |=> cfg_rdata[2]);
endmodule

bind irq_gather irq_gather_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .tmr_wrap  (tmr_wrap),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .irq_req   (irq_req),
    .vec_load  (vec_load),
    .vec_addr  (vec_addr)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        edge_rise_sel = 1'b1;
    logic        ext_pin = 1'b0;
    logic        tmr_wrap = 1'b0;
    logic [7:0]  port_pins = '0;
    logic        nvw_done = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic        vec_load;
    logic [12:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_gather u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .edge_rise_sel(edge_rise_sel), .ext_pin(ext_pin),
        .tmr_wrap(tmr_wrap), .port_pins(port_pins), .nvw_done(nvw_done),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .vec_load(vec_load), .vec_addr(vec_addr)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    initial begin
        port_pins = 8'hA5; ext_pin = 1'b1;
        step(); step();
        chk("R1 reg in reset", cfg_rdata, 0);
        chk("R1 req in reset", irq_req, 0);
        rst_n = 1'b1;
        step();
        chk("R1 reg after reset", cfg_rdata, 0);
        chk("R1 vec_load after reset", vec_load, 0);
        step();
        chk("R10 no flags from reset-time levels", cfg_rdata, 0);

        // R2 and R3: exhaustive sweep of register value and write-complete input
        for (int v = 0; v < 256; v++) begin
            for (int n = 0; n < 2; n++) begin
                nvw_done = n[0];
                wr(v[7:0]);
                begin
                    logic [7:0] r;
                    logic exp_req;
                    r = v[7:0];
                    exp_req = r[7] & ((r[6] & n[0]) | (r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]));
                    chk("R2 readback", cfg_rdata, v);
                    chk("R3 request", irq_req, exp_req);
                end
            end
        end
        nvw_done = 1'b0;
        wr(8'h00);

        // R8: each port line alone
        for (int i = 0; i < 8; i++) begin
            port_pins = port_pins ^ (8'h01 << i);
            step();
            chk("R8 port change sets bit0", cfg_rdata, 8'h01);
            wr(8'h00);
            step();
            chk("R8 no change keeps bit0 clear", cfg_rdata, 8'h00);
        end

        // R7: edge selection
        edge_rise_sel = 1'b1; ext_pin = 1'b0; step(); wr(8'h00);
        ext_pin = 1'b1; step();
        chk("R7 rising edge selected", cfg_rdata, 8'h02);
        wr(8'h00);
        ext_pin = 1'b0; step();
        chk("R7 falling edge ignored", cfg_rdata, 8'h00);
        edge_rise_sel = 1'b0; ext_pin = 1'b1; step();
        chk("R7 rising edge ignored", cfg_rdata, 8'h00);
        ext_pin = 1'b0; step();
        chk("R7 falling edge selected", cfg_rdata, 8'h02);
        wr(8'h00);

        // R6 and R9: timer flag, set wins over a clear in the same cycle
        tmr_wrap = 1'b1; step(); tmr_wrap = 1'b0;
        chk("R6 timer wrap sets bit2", cfg_rdata, 8'h04);
        tmr_wrap = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h00; step();
        tmr_wrap = 1'b0; cfg_wr = 1'b0;
        chk("R9 set wins over clear", cfg_rdata, 8'h04);
        step(); step(); step();
        chk("R9 flag sticky", cfg_rdata, 8'h04);

        // R4, R5, R9: take an interrupt, return and see it again
        wr(8'hA4);
        chk("R3 timer request", irq_req, 1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R4 ack clears global", cfg_rdata, 8'h24);
        chk("R4 request dropped", irq_req, 0);
        chk("R4 vec_load", vec_load, 1);
        chk("R4 vec_addr", vec_addr, 13'h0004);
        step();
        chk("R4 vec_load single cycle", vec_load, 0);
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
        chk("R5 ret sets global", cfg_rdata, 8'hA4);
        chk("R9 uncleared flag requests again", irq_req, 1);

        // R4: ack priority over ret and over a write
        irq_ack = 1'b1; irq_ret = 1'b1; step(); irq_ack = 1'b0; irq_ret = 1'b0;
        chk("R4 ack beats ret", cfg_rdata[7], 0);
        irq_ack = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h80; step();
        irq_ack = 1'b0; cfg_wr = 1'b0;
        chk("R4 ack beats write", cfg_rdata, 8'h00);
        chk("R4 vec after second ack", vec_load, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule